// File: doc/BRIEF.md
# DMA Channel Control and Status Register Unit

This block is the register file of one channel of a descriptor-driven DMA engine. Software reaches it through a 32-bit word-wide register port that covers a 128-byte window. It holds the channel status word, the command pointer, and three select words. These are the interrupt select, the branch select and the wait select. The descriptor engine beside it uses the status bits and the select words to decide what to do. The engine also takes one-cycle pulses from this block: one to fetch a descriptor, one to start or resume running, and one to flush its buffers.

Status is never written directly. A write to the control word carries a 16-bit mask in its upper half and a 16-bit value in its lower half. The masked merge touches only the run, pause, flush and wake flags and the 8-bit device status field. The active and dead flags are then derived from the merged flags, and pause always wins. When run drops, the channel is idled. A pending flush is handed to the engine as a pulse and then cleared. The command pointer is protected while the channel is busy and is always kept 16-byte aligned.

Top module: `dmach_regs`

## Requirements
- R1: After reset, the status word, the command pointer and all three select words are zero, and the fetch, run and flush pulses are low.
- R2: A full-word write to word offset 0 takes mask = wdata[31:16] and value = wdata[15:0]. Only status bits 15 (run), 14 (pause), 13 (flush), 12 (wake) and 7:0 (device status) are merged, as (value & mask) | (old & ~mask). Bits 11 (dead), 10 (active), 9 and 8 (branch-taken) are never loaded from the written data.
- R3: After the merge, a set wake or run flag sets active, and a set run flag clears dead.
- R4: A set pause flag clears active, and it overrides run and wake in the same write.
- R5: When a control write takes run from 1 to 0, active and dead are cleared. If flush is set in the merged word, flush_req_o pulses for one cycle and flush is cleared.
- R6: After any other control write whose merged word has flush set, flush_req_o pulses for one cycle and flush stays set.
- R7: After a control write whose final status has active set, run_req_o pulses for one cycle. Otherwise it stays low.
- R8: A write to word offset 3 (command pointer) is ignored while run or active is set. The pointer keeps its value and fetch_req_o stays low.
- R9: An accepted command-pointer write stores wdata with bits 3:0 forced to zero and pulses fetch_req_o for one cycle.
- R10: Word offsets 4, 5 and 6 hold the interrupt, branch and wait select words. They store and read back all 32 bits. A read of offset 1 returns the status in bits 15:0 and zero above. Read data appears on bus_rdata in the cycle after the request.
- R11: A read of offset 0, or of any offset other than 1, 3, 4, 5 and 6, returns zero. Writes to offsets other than 0, 3, 4, 5 and 6 change nothing, and this includes the status offset.
- R12: An access with bus_be other than 4'b1111 is ignored. A write changes no state and raises no pulse, and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address in the channel window; bits ADDR_W-1:2 select the word |
| bus_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| stat_o | output | 16 | Current status word |
| cmd_ptr_o | output | 32 | Current command pointer |
| intr_sel_o | output | 32 | Interrupt select word |
| brch_sel_o | output | 32 | Branch select word |
| wait_sel_o | output | 32 | Wait select word |
| fetch_req_o | output | 1 | One-cycle descriptor fetch request |
| run_req_o | output | 1 | One-cycle run request after a control write leaves active set |
| flush_req_o | output | 1 | One-cycle flush request |

## Verification
The bench aims at writes that set pause together with run or wake. A design that applies pause before deriving active would wrongly leave the channel active. It also drives run-to-zero writes with flush set, where a wrong design keeps flush set or misses the pulse. It drives writes whose mask reaches the dead and active bits, where a wrong design would let software load them directly. It tries command-pointer writes while the channel is busy, which a wrong design would accept, and pointer values with nonzero low bits, which a wrong design would store unaligned. Partial byte-enable accesses and reads of the control word must leave no trace and return zero. A design that decodes only the address would corrupt state there.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int ST_W = 16;
  localparam int DW   = 32;

  localparam int P_RUN   = 15;
  localparam int P_PAUSE = 14;
  localparam int P_FLUSH = 13;
  localparam int P_WAKE  = 12;
  localparam int P_DEAD  = 11;
  localparam int P_ACT   = 10;

  localparam logic [ST_W-1:0] WR_MASK = 16'hF0FF;

  localparam int OFS_CTL  = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_PTR  = 3;
  localparam int OFS_SEL0 = 4;
  localparam int NUM_SEL  = 3;

  typedef struct packed {
    logic [ST_W-1:0] st;
    logic            flush;
    logic            run;
  } ctl_res_t;

  // Masked merge followed by the derivation of active and dead.
  function automatic ctl_res_t ctl_apply(input logic [ST_W-1:0] old_st,
                                         input logic [DW-1:0]   wd);
    logic [ST_W-1:0] msk;
    logic [ST_W-1:0] s;
    ctl_res_t        r;
    msk = wd[31:16] & WR_MASK;
    s   = (wd[15:0] & msk) | (old_st & ~msk);
    if (s[P_WAKE]) s[P_ACT] = 1'b1;
    if (s[P_RUN]) begin
      s[P_ACT]  = 1'b1;
      s[P_DEAD] = 1'b0;
    end
    if (s[P_PAUSE]) s[P_ACT] = 1'b0;
    r.flush = 1'b0;
    if (old_st[P_RUN] && !s[P_RUN]) begin
      s[P_ACT]  = 1'b0;
      s[P_DEAD] = 1'b0;
      if (s[P_FLUSH]) begin
        r.flush    = 1'b1;
        s[P_FLUSH] = 1'b0;
      end
    end else begin
      r.flush = s[P_FLUSH];
    end
    r.st  = s;
    r.run = s[P_ACT];
    return r;
  endfunction

  function automatic logic [DW-1:0] ptr_align(input logic [DW-1:0] wd);
    return {wd[DW-1:4], 4'h0};
  endfunction
endpackage

// File: rtl/dmach_decode.sv
module dmach_decode #(
  parameter int ADDR_W = 7,
  localparam int WIDX_W = ADDR_W - 2
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output logic              acc_ok,
  output logic [WIDX_W-1:0] widx,
  output logic              wr_ctl,
  output logic              wr_ptr,
  output logic [dmach_pkg::NUM_SEL-1:0] wr_sel,
  output logic              rd_en
);
  import dmach_pkg::*;

  assign acc_ok = valid && (be == 4'hF);
  assign widx   = addr[ADDR_W-1:2];
  assign wr_ctl = acc_ok && write && (widx == WIDX_W'(OFS_CTL));
  assign wr_ptr = acc_ok && write && (widx == WIDX_W'(OFS_PTR));
  assign rd_en  = valid && !write;

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel_dec
    assign wr_sel[i] = acc_ok && write && (widx == WIDX_W'(OFS_SEL0 + i));
  end
endmodule

// File: rtl/dmach_status.sv
module dmach_status (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_ctl,
  input  logic [dmach_pkg::DW-1:0]   wdata,
  output logic [dmach_pkg::ST_W-1:0] stat_q,
  output logic                       run_req,
  output logic                       flush_req
);
  import dmach_pkg::*;

  ctl_res_t nxt;
  assign nxt = ctl_apply(stat_q, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= '0;
      run_req   <= 1'b0;
      flush_req <= 1'b0;
    end else begin
      run_req   <= wr_ctl && nxt.run;
      flush_req <= wr_ctl && nxt.flush;
      if (wr_ctl) stat_q <= nxt.st;
    end
  end
endmodule

// File: rtl/dmach_ptr.sv
module dmach_ptr (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_ptr,
  input  logic                     busy,
  input  logic [dmach_pkg::DW-1:0] wdata,
  output logic                     accept,
  output logic [dmach_pkg::DW-1:0] ptr_q,
  output logic                     fetch_req
);
  import dmach_pkg::*;

  assign accept = wr_ptr && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      fetch_req <= 1'b0;
    end else begin
      fetch_req <= accept;
      if (accept) ptr_q <= ptr_align(wdata);
    end
  end
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [15:0]       stat_o,
  output logic [31:0]       cmd_ptr_o,
  output logic [31:0]       intr_sel_o,
  output logic [31:0]       brch_sel_o,
  output logic [31:0]       wait_sel_o,
  output logic              fetch_req_o,
  output logic              run_req_o,
  output logic              flush_req_o
);
  import dmach_pkg::*;
  localparam int WIDX_W = ADDR_W - 2;

  logic              acc_ok_w;
  logic [WIDX_W-1:0] widx_w;
  logic              wr_ctl_w;
  logic              wr_ptr_w;
  logic [NUM_SEL-1:0] wr_sel_w;
  logic              rd_en_w;
  logic              busy_w;
  logic              ptr_accept_w;
  logic [DW-1:0]     sel_q [NUM_SEL];

  dmach_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid  (bus_valid),
    .write  (bus_write),
    .addr   (bus_addr),
    .be     (bus_be),
    .acc_ok (acc_ok_w),
    .widx   (widx_w),
    .wr_ctl (wr_ctl_w),
    .wr_ptr (wr_ptr_w),
    .wr_sel (wr_sel_w),
    .rd_en  (rd_en_w)
  );

  dmach_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctl    (wr_ctl_w),
    .wdata     (bus_wdata),
    .stat_q    (stat_o),
    .run_req   (run_req_o),
    .flush_req (flush_req_o)
  );

  assign busy_w = stat_o[P_RUN] || stat_o[P_ACT];

  dmach_ptr u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ptr    (wr_ptr_w),
    .busy      (busy_w),
    .wdata     (bus_wdata),
    .accept    (ptr_accept_w),
    .ptr_q     (cmd_ptr_o),
    .fetch_req (fetch_req_o)
  );

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q[i] <= '0;
      else if (wr_sel_w[i]) sel_q[i] <= bus_wdata;
    end
  end

  assign intr_sel_o = sel_q[0];
  assign brch_sel_o = sel_q[1];
  assign wait_sel_o = sel_q[2];

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (acc_ok_w) begin
      case (widx_w)
        WIDX_W'(OFS_STAT):     rd_mux = {16'h0, stat_o};
        WIDX_W'(OFS_PTR):      rd_mux = cmd_ptr_o;
        WIDX_W'(OFS_SEL0):     rd_mux = sel_q[0];
        WIDX_W'(OFS_SEL0 + 1): rd_mux = sel_q[1];
        WIDX_W'(OFS_SEL0 + 2): rd_mux = sel_q[2];
        default:               rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_en_w) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/dmach_regs_chk.sv
module dmach_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic [15:0] stat_o,
  input logic [31:0] cmd_ptr_o,
  input logic        fetch_req_o,
  input logic        run_req_o,
  input logic        flush_req_o,
  input logic        wr_ptr_w,
  input logic        busy_w
);
  a_r4_pause_wins: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[14] |-> !stat_o[10]);

  a_r3_run_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[15] |-> (!stat_o[11] && (stat_o[10] || stat_o[14])));

  a_r5_run_fall_idles: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_o[15]) && !stat_o[15]) |-> (!stat_o[10] && !stat_o[13]));

  a_r7_run_req_active: assert property (@(posedge clk) disable iff (!rst_n)
    run_req_o |-> stat_o[10]);

  a_r8_ptr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr_w && busy_w) |=> ($stable(cmd_ptr_o) && !fetch_req_o));

  a_r9_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr_w && !busy_w) |=> (fetch_req_o && cmd_ptr_o == {$past(bus_wdata[31:4]), 4'h0}));

  a_r12_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_be != 4'hF) |=>
      ($stable(stat_o) && !fetch_req_o && !run_req_o && !flush_req_o));
endmodule

bind dmach_regs dmach_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_be      (bus_be),
  .bus_wdata   (bus_wdata),
  .stat_o      (stat_o),
  .cmd_ptr_o   (cmd_ptr_o),
  .fetch_req_o (fetch_req_o),
  .run_req_o   (run_req_o),
  .flush_req_o (flush_req_o),
  .wr_ptr_w    (wr_ptr_w),
  .busy_w      (busy_w)
);

// File: tb/dmach_regs_tb_top.sv
module dmach_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] stat_o;
  logic [31:0] cmd_ptr_o, intr_sel_o, brch_sel_o, wait_sel_o;
  logic        fetch_req_o, run_req_o, flush_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_st = '0;
  logic [31:0] m_ptr = '0;
  logic [31:0] m_sel [3];

  always #10 clk = ~clk;

  dmach_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .stat_o(stat_o), .cmd_ptr_o(cmd_ptr_o),
    .intr_sel_o(intr_sel_o), .brch_sel_o(brch_sel_o), .wait_sel_o(wait_sel_o),
    .fetch_req_o(fetch_req_o), .run_req_o(run_req_o), .flush_req_o(flush_req_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Control-write model: returns {run pulse, flush pulse, status}.
  function automatic logic [17:0] mdl_ctl(input logic [15:0] o, input logic [31:0] w);
    logic run, pause, fl, wake, dead, act, fp;
    logic [7:0] dev;
    run   = w[31] ? w[15] : o[15];
    pause = w[30] ? w[14] : o[14];
    fl    = w[29] ? w[13] : o[13];
    wake  = w[28] ? w[12] : o[12];
    for (int k = 0; k < 8; k++) dev[k] = w[16+k] ? w[k] : o[k];
    dead = o[11] && !run;
    act  = (o[10] || wake || run) && !pause;
    fp   = fl;
    if (o[15] && !run) begin
      act = 0; dead = 0;
      fl  = 0;
    end
    return {act, fp, run, pause, fl, wake, dead, act, o[9], o[8], dev};
  endfunction

  task automatic acc(input bit wr, input int idx, input logic [3:0] be,
                     input logic [31:0] d, input string req);
    logic [17:0] r;
    logic exp_fetch, exp_run, exp_flush;
    logic [31:0] exp_rd;
    exp_fetch = 0; exp_run = 0; exp_flush = 0; exp_rd = 0;
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_addr = {idx[4:0], 2'b00}; bus_be = be; bus_wdata = d;
    if (be == 4'hF) begin
      if (wr) begin
        case (idx)
          0: begin r = mdl_ctl(m_st, d); m_st = r[15:0]; exp_run = r[17]; exp_flush = r[16]; end
          3: if (!m_st[15] && !m_st[10]) begin m_ptr = d & 32'hFFFF_FFF0; exp_fetch = 1; end
          4, 5, 6: m_sel[idx-4] = d;
          default: ;
        endcase
      end else begin
        case (idx)
          1: exp_rd = {16'h0, m_st};
          3: exp_rd = m_ptr;
          4, 5, 6: exp_rd = m_sel[idx-4];
          default: exp_rd = 0;
        endcase
      end
    end
    @(negedge clk);
    bus_valid = 0;
    chk({req, " status"}, {16'h0, stat_o}, {16'h0, m_st});
    chk({req, " pointer"}, cmd_ptr_o, m_ptr);
    chk({req, " fetch"}, {31'h0, fetch_req_o}, {31'h0, exp_fetch});
    chk({req, " run_req"}, {31'h0, run_req_o}, {31'h0, exp_run});
    chk({req, " flush"}, {31'h0, flush_req_o}, {31'h0, exp_flush});
    chk({req, " sel"}, intr_sel_o ^ brch_sel_o ^ wait_sel_o, m_sel[0] ^ m_sel[1] ^ m_sel[2]);
    if (!wr) chk({req, " rdata"}, bus_rdata, exp_rd);
  endtask

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    for (int i = 0; i < 3; i++) m_sel[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset status", {16'h0, stat_o}, 0);
    chk("R1 reset ptr", cmd_ptr_o, 0);
    chk("R1 reset sel", intr_sel_o | brch_sel_o | wait_sel_o, 0);
    chk("R1 reset pulses", {29'h0, fetch_req_o, run_req_o, flush_req_o}, 0);

    // Directed corners
    acc(1, 3, 4'hF, 32'h1234_567F, "R9 aligned ptr");
    acc(0, 3, 4'hF, 0, "R9 ptr read");
    acc(1, 0, 4'hF, 32'h0C00_0C00, "R2 dead/active not writable");
    acc(1, 0, 4'hF, 32'hC000_C000, "R4 pause over run");
    acc(1, 0, 4'hF, 32'h4000_0000, "R3 run sets active");
    acc(1, 3, 4'hF, 32'hAAAA_BBBB, "R8 ptr locked");
    acc(1, 0, 4'hF, 32'h2000_2000, "R6 flush while running");
    acc(1, 0, 4'hF, 32'h8000_0000, "R5 run fall flush");
    acc(1, 0, 4'hF, 32'h1000_1000, "R7 wake run_req");
    acc(1, 0, 4'hF, 32'h10FF_00A5, "R2 device status merge");
    acc(0, 0, 4'hF, 0, "R11 ctl reads zero");
    acc(1, 1, 4'hF, 32'hFFFF_FFFF, "R11 status write ignored");
    acc(0, 1, 4'hF, 0, "R10 status read");
    acc(1, 5, 4'hF, 32'hDEAD_BEEF, "R10 branch select");
    acc(0, 5, 4'hF, 0, "R10 branch select read");
    acc(1, 0, 4'h3, 32'h8000_8000, "R12 partial write");
    acc(0, 5, 4'h7, 0, "R12 partial read");
    acc(0, 9, 4'hF, 0, "R11 unused read");

    for (int n = 0; n < 1500; n++) begin
      int op, idx;
      logic [31:0] d;
      logic [3:0] be;
      op = $urandom_range(0, 9);
      d  = $urandom;
      be = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
      if (op < 4) acc(1, 0, be, d, "R2 R3 R4 R5 R6 R7 random control");
      else if (op < 6) acc(1, 3, be, d, "R8 R9 random ptr");
      else if (op < 7) begin idx = $urandom_range(0, 15); acc(1, idx, be, d, "R10 R11 R12 random write"); end
      else begin idx = $urandom_range(0, 31); acc(0, idx, be, 0, "R10 R11 R12 random read"); end
    end
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule